// File: doc/BRIEF.md
# Nine-bit multiprocessor UART receiver

This block receives asynchronous serial frames that carry a ninth bit after the data byte. A frame is a low start bit, the data bits (least significant first), the ninth bit, and a high stop bit. The line is sampled against a free-running oversampling tick. The received byte and its ninth bit appear on separate output registers, and a receive flag tells the surrounding logic that a new word is waiting.

A multiprocessor mode input lets a slave on a shared bus skip traffic that is meant for others. While the mode is set, only frames whose ninth bit is 1 (address frames) are delivered. Frames whose ninth bit is 0 (data frames) are dropped: they raise no flag and change no output. Control logic outside the block compares the delivered address with its own. On a match it drops the mode so the data frames that follow are delivered. It raises the mode again when the message ends.

A stop bit read as 0 is reported on a framing-error output. A word delivered while the previous one is still unread overwrites it and sets an overrun indicator. Baud generation, the transmitter and the address comparison are outside this block.

Top module: `mp_uart_rx`

## Requirements
- R1: A frame is one start bit (0), DATA_W data bits sent least significant first, one ninth bit, and one stop bit (1). Each bit lasts OVERSAMPLE baud ticks. A delivered frame places its data bits on rx_data and its ninth bit on rx_ninth.
- R2: With mp_mode low, every frame whose stop bit is 1 raises rx_flag and updates rx_data and rx_ninth, whatever its ninth bit.
- R3: With mp_mode high, a frame with ninth bit 1 and stop bit 1 raises rx_flag and updates rx_data and rx_ninth.
- R4: With mp_mode high, a frame with ninth bit 0 raises no flag and leaves rx_data, rx_ninth and overrun unchanged.
- R5: A low pulse on the line that ends before half a bit period is not taken as a start bit. The receiver returns to idle, changes no output, and receives the next proper frame correctly.
- R6: A frame whose stop bit is sampled as 0 sets frame_err. It raises no flag and leaves rx_data and rx_ninth unchanged.
- R7: rx_flag stays high until a one-cycle pulse on flag_clr. That pulse clears rx_flag, overrun and frame_err in the next cycle.
- R8: A frame that would raise rx_flag while rx_flag is already high overwrites rx_data and rx_ninth, keeps rx_flag high, and sets overrun.
- R9: After reset rx_data, rx_ninth, rx_flag, frame_err and overrun are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial input line; idles high |
| baud_tick | input | 1 | One-cycle pulse, OVERSAMPLE per bit period |
| mp_mode | input | 1 | Multiprocessor mode: deliver address frames only |
| flag_clr | input | 1 | Pulse that clears rx_flag, overrun and frame_err |
| rx_data | output | DATA_W | Last delivered data or address byte |
| rx_ninth | output | 1 | Ninth bit of the last delivered frame |
| rx_flag | output | 1 | A delivered word is waiting |
| frame_err | output | 1 | A frame ended with a stop bit of 0 |
| overrun | output | 1 | A word was delivered while rx_flag was high |

## Verification
The bench builds the block with OVERSAMPLE = 16, DATA_W = 8 and two synchronizer stages, and sends one baud tick every three clocks. Each bit then lasts 48 clocks, which leaves room to place a start glitch well short of the half-bit confirmation point. With the full 8-bit width, every data pattern and both ninth-bit values can reach the outputs. Random frames with random mode settings, ninth bits, broken stop bits and occasional clears exercise mode suppression, overrun and framing error together, alongside directed frames with fixed patterns.

// File: rtl/mpu_rx_pkg.sv
package mpu_rx_pkg;
   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_BITS  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_e;
endpackage

// File: rtl/mpu_rx_sync.sv
module mpu_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b1;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign d_out = chain[STAGES-1];
endmodule

// File: rtl/mpu_rx_frame.sv
module mpu_rx_frame
   import mpu_rx_pkg::*;
#(
   parameter int OVERSAMPLE = 16,
   parameter int DATA_W     = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            line_s,
   input  logic            tick,
   output logic            done,
   output logic [DATA_W:0] word,
   output logic            stop_ok
);
   localparam int CNT_W  = $clog2(OVERSAMPLE);
   localparam int NBITS  = DATA_W + 1;
   localparam int IDX_W  = $clog2(NBITS + 1);
   localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(OVERSAMPLE / 2 - 1);
   localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(OVERSAMPLE - 1);
   localparam logic [IDX_W-1:0] LAST_IX = IDX_W'(NBITS - 1);

   rx_state_e        state;
   logic [CNT_W-1:0] cnt;
   logic [IDX_W-1:0] idx;
   logic [DATA_W:0]  shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= RX_IDLE;
         cnt     <= '0;
         idx     <= '0;
         shreg   <= '0;
         done    <= 1'b0;
         stop_ok <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            case (state)
               RX_IDLE: begin
                  cnt <= '0;
                  if (!line_s) state <= RX_START;
               end
               RX_START: begin
                  if (cnt == HALF_M1) begin
                     cnt <= '0;
                     idx <= '0;
                     state <= line_s ? RX_IDLE : RX_BITS;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_BITS: begin
                  if (cnt == FULL_M1) begin
                     cnt   <= '0;
                     shreg <= {line_s, shreg[DATA_W:1]};
                     if (idx == LAST_IX) state <= RX_STOP;
                     else                idx   <= idx + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (cnt == FULL_M1) begin
                     cnt     <= '0;
                     done    <= 1'b1;
                     stop_ok <= line_s;
                     state   <= RX_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end

   assign word = shreg;
endmodule

// File: rtl/mpu_rx_flags.sv
module mpu_rx_flags #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic [DATA_W:0]   word,
   input  logic              stop_ok,
   input  logic              mp_mode,
   input  logic              flag_clr,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_ninth,
   output logic              rx_flag,
   output logic              frame_err,
   output logic              overrun
);
   logic accept;
   logic bad_stop;

   assign accept   = done && stop_ok && (!mp_mode || word[DATA_W]);
   assign bad_stop = done && !stop_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data  <= '0;
         rx_ninth <= 1'b0;
         rx_flag  <= 1'b0;
         overrun  <= 1'b0;
      end else if (accept) begin
         rx_data  <= word[DATA_W-1:0];
         rx_ninth <= word[DATA_W];
         rx_flag  <= 1'b1;
         if (rx_flag && !flag_clr) overrun <= 1'b1;
         else if (flag_clr)        overrun <= 1'b0;
      end else if (flag_clr) begin
         rx_flag <= 1'b0;
         overrun <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        frame_err <= 1'b0;
      else if (bad_stop) frame_err <= 1'b1;
      else if (flag_clr) frame_err <= 1'b0;
   end
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
   parameter int OVERSAMPLE  = 16,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_line,
   input  logic              baud_tick,
   input  logic              mp_mode,
   input  logic              flag_clr,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_ninth,
   output logic              rx_flag,
   output logic              frame_err,
   output logic              overrun
);
   generate
      if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_ovs
         $error("OVERSAMPLE must be even and at least 4");
      end
      if (DATA_W < 1) begin : g_bad_w
         $error("DATA_W must be at least 1");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic            line_s;
   logic            fr_done;
   logic [DATA_W:0] fr_word;
   logic            fr_stop_ok;

   mpu_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (rx_line),
      .d_out (line_s)
   );

   mpu_rx_frame #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W)) frame_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_s  (line_s),
      .tick    (baud_tick),
      .done    (fr_done),
      .word    (fr_word),
      .stop_ok (fr_stop_ok)
   );

   mpu_rx_flags #(.DATA_W(DATA_W)) flags_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .done      (fr_done),
      .word      (fr_word),
      .stop_ok   (fr_stop_ok),
      .mp_mode   (mp_mode),
      .flag_clr  (flag_clr),
      .rx_data   (rx_data),
      .rx_ninth  (rx_ninth),
      .rx_flag   (rx_flag),
      .frame_err (frame_err),
      .overrun   (overrun)
   );
endmodule

// File: rtl/mpu_rx_chk.sv
module mpu_rx_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mp_mode,
   input logic              flag_clr,
   input logic              fr_done,
   input logic [DATA_W:0]   fr_word,
   input logic              fr_stop_ok,
   input logic [DATA_W-1:0] rx_data,
   input logic              rx_ninth,
   input logic              rx_flag,
   input logic              frame_err,
   input logic              overrun
);
   p_mp_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fr_done && mp_mode && !fr_word[DATA_W]
      |=> $stable(rx_data) && $stable(rx_ninth) && $stable(rx_flag) && $stable(overrun));

   p_bad_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fr_done && !fr_stop_ok |=> frame_err && $stable(rx_data) && $stable(rx_flag));

   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr && !fr_done |=> !rx_flag && !overrun && !frame_err);

   p_flag_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_flag) |-> $past(fr_done));

   p_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> $past(rx_flag) && rx_flag);

   p_addr_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_flag) && $past(mp_mode) |-> rx_ninth);

   p_deliver_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fr_done && fr_stop_ok && !mp_mode |=> rx_flag && rx_data == $past(fr_word[DATA_W-1:0]));
endmodule

bind mp_uart_rx mpu_rx_chk #(.DATA_W(DATA_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .mp_mode    (mp_mode),
   .flag_clr   (flag_clr),
   .fr_done    (fr_done),
   .fr_word    (fr_word),
   .fr_stop_ok (fr_stop_ok),
   .rx_data    (rx_data),
   .rx_ninth   (rx_ninth),
   .rx_flag    (rx_flag),
   .frame_err  (frame_err),
   .overrun    (overrun)
);

// File: tb/mp_uart_rx_tb_top.sv
`timescale 1ns/1ps
module mp_uart_rx_tb_top;
   localparam int OVS     = 16;
   localparam int DW      = 8;
   localparam int TICKDIV = 3;
   localparam int BITCLK  = OVS * TICKDIV;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_line = 1'b1;
   logic          baud_tick = 1'b0;
   logic          mp_mode = 1'b0;
   logic          flag_clr = 1'b0;
   logic [DW-1:0] rx_data;
   logic          rx_ninth, rx_flag, frame_err, overrun;

   int n_chk = 0;
   int n_bad = 0;
   int tdiv = 0;
   bit finished = 0;

   logic [DW-1:0] e_data = '0;
   logic          e_ninth = 0, e_flag = 0, e_ferr = 0, e_ovr = 0;

   always #2.5 clk = ~clk;

   always @(posedge clk) begin
      tdiv      <= (tdiv == TICKDIV - 1) ? 0 : tdiv + 1;
      baud_tick <= (tdiv == TICKDIV - 1);
   end

   mp_uart_rx #(.OVERSAMPLE(OVS), .DATA_W(DW), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .baud_tick(baud_tick),
      .mp_mode(mp_mode), .flag_clr(flag_clr), .rx_data(rx_data),
      .rx_ninth(rx_ninth), .rx_flag(rx_flag), .frame_err(frame_err),
      .overrun(overrun)
   );

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic check_all(string req);
      @(negedge clk);
      check(req, "rx_data", 32'(rx_data), 32'(e_data));
      check(req, "rx_ninth", 32'(rx_ninth), 32'(e_ninth));
      check(req, "rx_flag", 32'(rx_flag), 32'(e_flag));
      check(req, "frame_err", 32'(frame_err), 32'(e_ferr));
      check(req, "overrun", 32'(overrun), 32'(e_ovr));
   endtask

   // expected-state update for one received frame
   function automatic void model_frame(logic [DW-1:0] d, logic nb, logic stop_ok, logic mp);
      if (!stop_ok) begin
         e_ferr = 1'b1;
      end else if (!mp || nb) begin
         if (e_flag) e_ovr = 1'b1;
         e_flag  = 1'b1;
         e_data  = d;
         e_ninth = nb;
      end
   endfunction

   task automatic drive_bit(logic b);
      rx_line = b;
      repeat (BITCLK) @(posedge clk);
   endtask

   task automatic send_frame(logic [DW-1:0] d, logic nb, logic stop_ok);
      drive_bit(1'b0);
      for (int i = 0; i < DW; i++) drive_bit(d[i]);
      drive_bit(nb);
      drive_bit(stop_ok);
      rx_line = 1'b1;
      repeat (BITCLK) @(posedge clk);
      model_frame(d, nb, stop_ok, mp_mode);
   endtask

   task automatic clear_flags();
      @(negedge clk);
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
      e_flag = 0; e_ovr = 0; e_ferr = 0;
   endtask

   initial begin
      void'($urandom(32'h5eed_0901));
      repeat (5) @(posedge clk);
      // R9: reset state
      check_all("R9");
      rst_n = 1'b1;
      repeat (10) @(posedge clk);
      check_all("R9");

      // R1/R2: plain data frame, mode off
      mp_mode = 1'b0;
      send_frame(8'hA5, 1'b0, 1'b1);
      check_all("R1");
      clear_flags();
      check_all("R7");
      send_frame(8'h01, 1'b1, 1'b1);
      check_all("R2");
      clear_flags();

      // R3/R4: mode on, address then suppressed data
      mp_mode = 1'b1;
      send_frame(8'h3C, 1'b1, 1'b1);
      check_all("R3");
      send_frame(8'hFF, 1'b0, 1'b1);
      check_all("R4");
      clear_flags();
      send_frame(8'h80, 1'b0, 1'b1);
      check_all("R4");

      // R8: two delivered frames without clearing
      mp_mode = 1'b0;
      send_frame(8'h11, 1'b0, 1'b1);
      send_frame(8'h22, 1'b0, 1'b1);
      check_all("R8");
      clear_flags();
      check_all("R7");

      // R6: broken stop bit
      send_frame(8'h5A, 1'b1, 1'b0);
      check_all("R6");
      clear_flags();

      // R5: start glitch of 4 ticks, well below half a bit
      @(negedge clk);
      rx_line = 1'b0;
      repeat (4 * TICKDIV) @(posedge clk);
      rx_line = 1'b1;
      repeat (3 * BITCLK) @(posedge clk);
      check_all("R5");
      send_frame(8'hC3, 1'b0, 1'b1);
      check_all("R5");
      clear_flags();

      // random mix
      for (int k = 0; k < 48; k++) begin
         logic [DW-1:0] d;
         logic nb, so;
         d  = DW'($urandom);
         nb = 1'($urandom);
         so = ($urandom % 8) != 0;
         mp_mode = 1'($urandom);
         send_frame(d, nb, so);
         check_all(mp_mode ? "R4" : "R2");
         if (($urandom % 3) == 0) begin
            clear_flags();
            check_all("R7");
         end
      end

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule